// File: doc/BRIEF.md
# Associative Memory Control Decoder

This block sits at the front of a small content-addressable memory device. It watches a chip-enable strobe and, once per enable cycle, samples a 32-bit data bus, an address-valid line, a shared address/control bus, a write line, a validity input and a data-segment line. From one sample it decides whether the cycle is a random access to the memory array or a register or command operation. It then issues exactly one decoded cycle strobe to the array, along with the address, data, mask choice and segment flag that belong to it.

The decoder owns the device's local register set: a comparand, seven mask registers, a configuration word, an address pointer, a device-select word and an instruction word. The status index belongs to the array. In hardware mode the address/control bus carries either a memory address or a command, depending on the address-valid line. In software mode commands come from the instruction register, which is loaded over the data bus. In that mode the array can only be reached through the address pointer.

Top module: `amcd_decoder`

## Requirements
- R1: A cycle is decoded only on a high-to-low transition of `enN` seen at a rising clock edge. Its strobe is high for exactly the one clock that follows that edge, at most one strobe is high at a time, and holding `enN` low does not repeat the cycle.
- R2: The device is selected when `csAN` or `csBN` is low. It is also selected when the device-select word has bit PAGEW (enable, active low) at 0 and its bits PAGEW-1:0 equal the configured page. A cycle that is not selected raises no strobe, leaves every output unchanged and changes no register.
- R3: In hardware mode with `avN` low, the cycle is a direct memory access: a read if `writeN` is high, a write if it is low. `memAddr` is `ac`, `wrValid` copies `vbIn`, `segSel` is 0, and `maskSel` is the configured mask field on writes and 0 on reads.
- R4: In hardware mode with `avN` high, the opcode is `ac[3:0]`, the operand is `ac[7:4]` (driven on `regIdx`) and `segSel` copies `dsc`. The opcodes are: 1 register access, 2 indirect memory access, 3 compare, 4 move, 5 validity control, 6 init, 7 address-pointer clear. Opcodes 0 and 8 to 15 raise no strobe.
- R5: For register access, the operand selects the register: 0 comparand, 1 to 7 masks, 8 configuration, 9 status, 10 address pointer, 11 device select, 12 instruction. `writeN` low gives `regWr` and stores `dq`. `writeN` high gives `regRd`, and `rdData` takes the register's value. Index 9 and indexes 13 to 15 store nothing locally and read as 0.
- R6: The configuration word uses bit 0 for the mode (1 = software), bits 3:1 for the mask applied to direct writes, and bits PAGEW+3:4 for the device page.
- R7: An indirect access drives `memAddr` from the address pointer and afterwards increments the pointer, wrapping from 2^AW-1 to 0. `maskSel` is 0 on indirect writes.
- R8: In software mode, a cycle with `avN` high loads `dq` into the instruction register and raises no strobe. A cycle with `avN` low executes the held instruction (opcode in bits 3:0, operand in bits 7:4, segment in bit 8) with `dq` as data, and ignores `ac` and `dsc`. Direct addressing is not possible in this mode.
- R9: Validity control raises `vbStb` with `memAddr` from the pointer and `wrValid` equal to operand bit 0. Address-pointer clear raises `arStb` and sets the pointer to 0.
- R10: Compare, move and init raise `cmpStb`, `moveStb` and `initStb`. On every selected, executed cycle, `wrData` takes `dq`, and `memAddr` takes the pointer on cycles that are not direct accesses.
- R11: After reset all strobes and data outputs are 0, the mode is hardware, the registers are 0 and the device-select enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enN | input | 1 | Chip enable; its falling edge starts a cycle |
| csAN | input | 1 | Select A, active low |
| csBN | input | 1 | Select B, active low |
| writeN | input | 1 | Low for write, high for read |
| avN | input | 1 | Address valid: low = address or data, high = control or instruction |
| dsc | input | 1 | Data segment control used in hardware mode |
| vbIn | input | 1 | Validity value for memory writes |
| ac | input | AW | Address/control bus |
| dq | input | DW | Data bus |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| regRd | output | 1 | Register read strobe |
| regWr | output | 1 | Register write strobe |
| cmpStb | output | 1 | Compare strobe |
| moveStb | output | 1 | Move strobe |
| vbStb | output | 1 | Validity control strobe |
| initStb | output | 1 | Init strobe |
| arStb | output | 1 | Address pointer control strobe |
| memAddr | output | AW | Array address of the decoded cycle |
| wrValid | output | 1 | Validity value for the array |
| maskSel | output | 3 | Mask register to apply (0 = none) |
| segSel | output | 1 | Segment flag of the command |
| regIdx | output | 4 | Operand or register index |
| wrData | output | DW | Data sampled with the cycle |
| rdData | output | DW | Value of the last register read |

## Verification
The decode is driven through a table of hardware-mode cycles. The table covers direct reads and writes, each opcode, an unused opcode with a non-zero operand, and register writes followed by read-back. These rows separate the address source (bus versus pointer), the mask source (configuration versus none) and the segment source (`dsc` versus zero). Pointer rows walk across the wrap from 2^AW-1 to 0. Directed sequences then cover the following:
- select through each line, through a matching device-select word, and refusal on a page mismatch or a set enable bit;
- software-mode instruction loads, with a bus address that would differ from the pointer;
- `enN` held low across several clocks;
- a reset in the middle of a run.

// File: rtl/amcd_pkg.sv
package amcd_pkg;

  localparam int OPW     = 4;
  localparam int NUM_MASK = 7;
  localparam int INSTR_W = 9;

  localparam logic [OPW-1:0] IDX_CMPD  = 4'd0;
  localparam logic [OPW-1:0] IDX_CFG   = 4'd8;
  localparam logic [OPW-1:0] IDX_STAT  = 4'd9;
  localparam logic [OPW-1:0] IDX_ADDR  = 4'd10;
  localparam logic [OPW-1:0] IDX_DSEL  = 4'd11;
  localparam logic [OPW-1:0] IDX_INSTR = 4'd12;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 4'd0,
    OP_REG    = 4'd1,
    OP_MEMIND = 4'd2,
    OP_CMP    = 4'd3,
    OP_MOVE   = 4'd4,
    OP_VALID  = 4'd5,
    OP_INIT   = 4'd6,
    OP_ARCLR  = 4'd7
  } opcode_e;

  typedef struct packed {
    logic memRd;
    logic memWr;
    logic regRd;
    logic regWr;
    logic cmp;
    logic move;
    logic vbCtl;
    logic init;
    logic arCtl;
  } cycStb_t;

  typedef struct packed {
    cycStb_t        stb;
    logic           go;
    logic           loadInstr;
    logic           regWrite;
    logic           direct;
    logic           arInc;
    logic           arClr;
    logic           vbFromOp;
    logic           seg;
    logic [OPW-1:0] idx;
  } ctlCmd_t;

endpackage

// File: rtl/amcd_ctrl.sv
module amcd_ctrl
  import amcd_pkg::*;
#(
  parameter int PAGEW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enN,
  input  logic                 csAN,
  input  logic                 csBN,
  input  logic                 writeN,
  input  logic                 avN,
  input  logic                 dsc,
  input  logic [2*OPW-1:0]     acCode,
  input  logic                 swMode,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic                 devOffN,
  input  logic [PAGEW-1:0]     devPage,
  input  logic [PAGEW-1:0]     cfgPage,
  output ctlCmd_t              cmd
);

  logic enPrev;
  logic start;
  logic selected;
  logic [OPW-1:0] opSrc;
  logic [OPW-1:0] operand;
  logic segSrc;

  // enable edge detector; reset low so a held-low enable never starts a cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enN;
  end

  assign start    = enPrev & ~enN;
  assign selected = ~csAN | ~csBN | (~devOffN & (devPage == cfgPage));

  assign opSrc   = swMode ? instrWord[OPW-1:0]     : acCode[OPW-1:0];
  assign operand = swMode ? instrWord[2*OPW-1:OPW] : acCode[2*OPW-1:OPW];
  assign segSrc  = swMode ? instrWord[2*OPW]       : dsc;

  always_comb begin
    cmd = '0;
    if (start && selected) begin
      if (!swMode && !avN) begin
        cmd.go        = 1'b1;
        cmd.direct    = 1'b1;
        cmd.stb.memRd = writeN;
        cmd.stb.memWr = ~writeN;
      end else if (swMode && avN) begin
        cmd.loadInstr = 1'b1;
      end else begin
        cmd.go  = 1'b1;
        cmd.idx = operand;
        cmd.seg = segSrc;
        case (opSrc)
          OP_REG: begin
            cmd.stb.regRd = writeN;
            cmd.stb.regWr = ~writeN;
            cmd.regWrite  = ~writeN;
          end
          OP_MEMIND: begin
            cmd.stb.memRd = writeN;
            cmd.stb.memWr = ~writeN;
            cmd.arInc     = 1'b1;
          end
          OP_CMP:   cmd.stb.cmp = 1'b1;
          OP_MOVE:  cmd.stb.move = 1'b1;
          OP_VALID: begin
            cmd.stb.vbCtl = 1'b1;
            cmd.vbFromOp  = 1'b1;
          end
          OP_INIT:  cmd.stb.init = 1'b1;
          OP_ARCLR: begin
            cmd.stb.arCtl = 1'b1;
            cmd.arClr     = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: software mode never produces a direct array access
  p_sw_indirect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (swMode && (cmd.stb.memRd || cmd.stb.memWr)) |-> cmd.arInc);

  // R1: nothing is decoded while the enable has not just fallen
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enN || $past(!enN)) |-> (cmd == '0));

endmodule

// File: rtl/amcd_dpath.sv
module amcd_dpath
  import amcd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int PAGEW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlCmd_t             cmd,
  input  logic [AW-1:0]       ac,
  input  logic [DW-1:0]       dq,
  input  logic                vbIn,
  output cycStb_t             stbQ,
  output logic [AW-1:0]       memAddrQ,
  output logic                wrValidQ,
  output logic [2:0]          maskQ,
  output logic                segQ,
  output logic [OPW-1:0]      idxQ,
  output logic [DW-1:0]       wrDataQ,
  output logic [DW-1:0]       rdDataQ,
  output logic                cfgSw,
  output logic [PAGEW-1:0]    cfgPage,
  output logic                devOffN,
  output logic [PAGEW-1:0]    devPage,
  output logic [INSTR_W-1:0]  instrWord
);

  localparam logic [DW-1:0] DSEL_RST = DW'(1) << PAGEW;

  logic [DW-1:0] cmpdR;
  logic [DW-1:0] cfgR;
  logic [DW-1:0] dselR;
  logic [DW-1:0] instrR;
  logic [AW-1:0] addrR;
  logic [DW-1:0] maskR [NUM_MASK];
  logic [DW-1:0] readVal;

  function automatic logic wrHit(input ctlCmd_t c, input logic [OPW-1:0] target);
    return c.regWrite && (c.idx == target);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpdR  <= '0;
      cfgR   <= '0;
      dselR  <= DSEL_RST;
      instrR <= '0;
    end else begin
      if (wrHit(cmd, IDX_CMPD)) cmpdR <= dq;
      if (wrHit(cmd, IDX_CFG))  cfgR  <= dq;
      if (wrHit(cmd, IDX_DSEL)) dselR <= dq;
      if (cmd.loadInstr || wrHit(cmd, IDX_INSTR)) instrR <= dq;
    end
  end

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          maskR[g] <= '0;
      else if (wrHit(cmd, OPW'(g + 1)))   maskR[g] <= dq;
    end
  end

  // address pointer: clear wins over load, load wins over step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    addrR <= '0;
    else if (cmd.arClr)           addrR <= '0;
    else if (wrHit(cmd, IDX_ADDR)) addrR <= dq[AW-1:0];
    else if (cmd.arInc)           addrR <= addrR + 1'b1;
  end

  always_comb begin
    readVal = '0;
    if (cmd.idx == IDX_CMPD)       readVal = cmpdR;
    else if (cmd.idx < IDX_CFG)    readVal = maskR[cmd.idx[2:0] - 3'd1];
    else if (cmd.idx == IDX_CFG)   readVal = cfgR;
    else if (cmd.idx == IDX_ADDR)  readVal = DW'(addrR);
    else if (cmd.idx == IDX_DSEL)  readVal = dselR;
    else if (cmd.idx == IDX_INSTR) readVal = instrR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ     <= '0;
      memAddrQ <= '0;
      wrValidQ <= 1'b0;
      maskQ    <= '0;
      segQ     <= 1'b0;
      idxQ     <= '0;
      wrDataQ  <= '0;
      rdDataQ  <= '0;
    end else begin
      stbQ <= cmd.stb;
      if (cmd.go) begin
        memAddrQ <= cmd.direct ? ac : addrR;
        wrValidQ <= cmd.vbFromOp ? cmd.idx[0] : vbIn;
        maskQ    <= (cmd.direct && cmd.stb.memWr) ? cfgR[3:1] : 3'd0;
        segQ     <= cmd.seg;
        idxQ     <= cmd.idx;
        wrDataQ  <= dq;
        if (cmd.stb.regRd) rdDataQ <= readVal;
      end
    end
  end

  assign cfgSw     = cfgR[0];
  assign cfgPage   = cfgR[PAGEW+3:4];
  assign devOffN   = dselR[PAGEW];
  assign devPage   = dselR[PAGEW-1:0];
  assign instrWord = instrR[INSTR_W-1:0];

  // R1: at most one cycle strobe at a time
  p_onehot_stb_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbQ));

  // R7: an indirect access advances the pointer by one
  p_ar_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.arInc |=> (addrR == AW'($past(addrR) + 1'b1)));

  // R3: a memory write carries the sampled validity input
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stb.memWr |=> (wrValidQ == $past(vbIn)));

  // R8: writes issued in software mode carry no mask
  p_sw_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stb.memWr && cfgSw) |=> (maskQ == 3'd0));

  // R9: pointer clear leaves the pointer at zero
  p_ar_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.arClr |=> (addrR == '0));

endmodule

// File: rtl/amcd_decoder.sv
module amcd_decoder
  import amcd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int PAGEW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enN,
  input  logic          csAN,
  input  logic          csBN,
  input  logic          writeN,
  input  logic          avN,
  input  logic          dsc,
  input  logic          vbIn,
  input  logic [AW-1:0] ac,
  input  logic [DW-1:0] dq,
  output logic          memRd,
  output logic          memWr,
  output logic          regRd,
  output logic          regWr,
  output logic          cmpStb,
  output logic          moveStb,
  output logic          vbStb,
  output logic          initStb,
  output logic          arStb,
  output logic [AW-1:0] memAddr,
  output logic          wrValid,
  output logic [2:0]    maskSel,
  output logic          segSel,
  output logic [3:0]    regIdx,
  output logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);

  ctlCmd_t              cmd;
  cycStb_t              stbQ;
  logic                 cfgSw;
  logic [PAGEW-1:0]     cfgPage;
  logic                 devOffN;
  logic [PAGEW-1:0]     devPage;
  logic [INSTR_W-1:0]   instrWord;

  amcd_ctrl #(.PAGEW(PAGEW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enN(enN), .csAN(csAN), .csBN(csBN),
    .writeN(writeN), .avN(avN), .dsc(dsc), .acCode(ac[2*OPW-1:0]),
    .swMode(cfgSw), .instrWord(instrWord), .devOffN(devOffN),
    .devPage(devPage), .cfgPage(cfgPage), .cmd(cmd)
  );

  amcd_dpath #(.DW(DW), .AW(AW), .PAGEW(PAGEW)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ac(ac), .dq(dq), .vbIn(vbIn),
    .stbQ(stbQ), .memAddrQ(memAddr), .wrValidQ(wrValid), .maskQ(maskSel),
    .segQ(segSel), .idxQ(regIdx), .wrDataQ(wrData), .rdDataQ(rdData),
    .cfgSw(cfgSw), .cfgPage(cfgPage), .devOffN(devOffN),
    .devPage(devPage), .instrWord(instrWord)
  );

  assign {memRd, memWr, regRd, regWr, cmpStb, moveStb, vbStb, initStb, arStb} = stbQ;

  // R1: any strobe follows a falling enable seen one edge earlier
  p_stb_after_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|stbQ) |-> (!$past(enN) && $past(enN, 2)));

endmodule

// File: tb/tb_amcd_decoder.sv
module tb_amcd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  localparam logic [8:0] S_MRD = 9'h100, S_MWR = 9'h080, S_RRD = 9'h040,
                         S_RWR = 9'h020, S_CMP = 9'h010, S_MOV = 9'h008,
                         S_VB  = 9'h004, S_INI = 9'h002, S_ARC = 9'h001,
                         S_NONE = 9'h000;

  typedef struct packed {
    logic        av;
    logic        wr;
    logic        ds;
    logic        vb;
    logic [9:0]  a;
    logic [31:0] d;
    logic [8:0]  eStb;
    logic [9:0]  eAddr;
    logic        eValid;
    logic [2:0]  eMask;
    logic        eSeg;
    logic [3:0]  eIdx;
    logic [31:0] eRd;
  } vec_t;

  // hardware-mode sequence; pointer starts at 0, configuration at 0
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,10'h081,32'h0000_0034,S_RWR,10'h000,1'b0,3'd0,1'b0,4'h8,32'h0}, // R6 cfg: mask 2, page 3
    '{1'b0,1'b0,1'b0,1'b1,10'h155,32'hDEAD_BEEF,S_MWR,10'h155,1'b1,3'd2,1'b0,4'h0,32'h0}, // R3 direct write
    '{1'b0,1'b1,1'b1,1'b0,10'h3FF,32'h0000_0011,S_MRD,10'h3FF,1'b0,3'd0,1'b0,4'h0,32'h0}, // R3 direct read, dsc unused
    '{1'b1,1'b0,1'b0,1'b0,10'h0A1,32'h0000_03FE,S_RWR,10'h000,1'b0,3'd0,1'b0,4'hA,32'h0}, // R5 load pointer
    '{1'b1,1'b0,1'b0,1'b1,10'h002,32'h0000_A5A5,S_MWR,10'h3FE,1'b1,3'd0,1'b0,4'h0,32'h0}, // R7 indirect write
    '{1'b1,1'b1,1'b0,1'b0,10'h002,32'h0000_0000,S_MRD,10'h3FF,1'b0,3'd0,1'b0,4'h0,32'h0}, // R7
    '{1'b1,1'b1,1'b0,1'b0,10'h002,32'h0000_0000,S_MRD,10'h000,1'b0,3'd0,1'b0,4'h0,32'h0}, // R7 wrap
    '{1'b1,1'b1,1'b1,1'b0,10'h003,32'hCAFE_0001,S_CMP,10'h001,1'b0,3'd0,1'b1,4'h0,32'h0}, // R10 compare, seg
    '{1'b1,1'b1,1'b0,1'b0,10'h004,32'h0000_0002,S_MOV,10'h001,1'b0,3'd0,1'b0,4'h0,32'h0}, // R10 move
    '{1'b1,1'b1,1'b0,1'b0,10'h015,32'h0000_0003,S_VB ,10'h001,1'b1,3'd0,1'b0,4'h1,32'h0}, // R9 validity from operand
    '{1'b1,1'b1,1'b0,1'b0,10'h007,32'h0000_0004,S_ARC,10'h001,1'b0,3'd0,1'b0,4'h0,32'h0}, // R9 pointer clear
    '{1'b1,1'b1,1'b0,1'b0,10'h006,32'h0000_0005,S_INI,10'h000,1'b0,3'd0,1'b0,4'h0,32'h0}, // R10 init
    '{1'b1,1'b1,1'b0,1'b0,10'h000,32'h0000_0006,S_NONE,10'h000,1'b0,3'd0,1'b0,4'h0,32'h0}, // R4 opcode 0
    '{1'b1,1'b1,1'b0,1'b0,10'h0FA,32'h0000_0009,S_NONE,10'h000,1'b0,3'd0,1'b0,4'hF,32'h0}, // R4 unused opcode
    '{1'b1,1'b0,1'b0,1'b0,10'h031,32'h0F0F_0F0F,S_RWR,10'h000,1'b0,3'd0,1'b0,4'h3,32'h0}, // R5 mask write
    '{1'b1,1'b1,1'b0,1'b0,10'h031,32'h0000_0000,S_RRD,10'h000,1'b0,3'd0,1'b0,4'h3,32'h0F0F_0F0F}, // R5
    '{1'b1,1'b1,1'b0,1'b0,10'h081,32'h0000_0000,S_RRD,10'h000,1'b0,3'd0,1'b0,4'h8,32'h0000_0034}, // R6
    '{1'b1,1'b1,1'b0,1'b0,10'h091,32'h0000_0000,S_RRD,10'h000,1'b0,3'd0,1'b0,4'h9,32'h0}, // R5 status reads 0
    '{1'b1,1'b0,1'b0,1'b0,10'h0E1,32'h0000_FFFF,S_RWR,10'h000,1'b0,3'd0,1'b0,4'hE,32'h0}, // R5 unused index
    '{1'b1,1'b1,1'b0,1'b0,10'h0E1,32'h0000_0000,S_RRD,10'h000,1'b0,3'd0,1'b0,4'hE,32'h0}  // R5 reads 0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enN = 1'b1, csAN = 1'b1, csBN = 1'b1, writeN = 1'b1, avN = 1'b1;
  logic dsc = 1'b0, vbIn = 1'b0;
  logic [9:0]  ac = '0;
  logic [31:0] dq = '0;
  logic memRd, memWr, regRd, regWr, cmpStb, moveStb, vbStb, initStb, arStb;
  logic [9:0]  memAddr;
  logic        wrValid;
  logic [2:0]  maskSel;
  logic        segSel;
  logic [3:0]  regIdx;
  logic [31:0] wrData, rdData;

  logic [8:0]  capStb, afterStb;
  logic [9:0]  capAddr;
  logic        capValid, capSeg;
  logic [2:0]  capMask;
  logic [3:0]  capIdx;
  logic [31:0] capWr, capRd;
  int nChk = 0;
  int nFail = 0;
  vec_t v;

  amcd_decoder dut (
    .clk(clk), .rstN(rstN), .enN(enN), .csAN(csAN), .csBN(csBN),
    .writeN(writeN), .avN(avN), .dsc(dsc), .vbIn(vbIn), .ac(ac), .dq(dq),
    .memRd(memRd), .memWr(memWr), .regRd(regRd), .regWr(regWr),
    .cmpStb(cmpStb), .moveStb(moveStb), .vbStb(vbStb), .initStb(initStb),
    .arStb(arStb), .memAddr(memAddr), .wrValid(wrValid), .maskSel(maskSel),
    .segSel(segSel), .regIdx(regIdx), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] stbNow();
    return {memRd, memWr, regRd, regWr, cmpStb, moveStb, vbStb, initStb, arStb};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one enable cycle: drive, drop enable, capture after the sample edge,
  // raise enable, capture strobes one clock later
  task automatic doCyc(input logic selA, input logic selB, input logic a_v,
                       input logic w, input logic ds, input logic vb,
                       input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    csAN = selA; csBN = selB; avN = a_v; writeN = w; dsc = ds; vbIn = vb;
    ac = a; dq = d; enN = 1'b0;
    @(negedge clk);
    capStb = stbNow(); capAddr = memAddr; capValid = wrValid; capMask = maskSel;
    capSeg = segSel; capIdx = regIdx; capWr = wrData; capRd = rdData;
    enN = 1'b1;
    @(negedge clk);
    afterStb = stbNow();
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; enN = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    resetDut();
    // R11 reset state
    chk("R11 strobes after reset", 32'(stbNow()), 32'h0);
    chk("R11 memAddr after reset", 32'(memAddr), 32'h0);
    chk("R11 wrData after reset", wrData, 32'h0);
    chk("R11 rdData after reset", rdData, 32'h0);

    // table walk, selected through csAN
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      doCyc(1'b0, 1'b1, v.av, v.wr, v.ds, v.vb, v.a, v.d);
      chk($sformatf("R4 row%0d strobe", i), 32'(capStb), 32'(v.eStb));
      chk($sformatf("R3 R7 row%0d memAddr", i), 32'(capAddr), 32'(v.eAddr));
      chk($sformatf("R3 R9 row%0d wrValid", i), 32'(capValid), 32'(v.eValid));
      chk($sformatf("R6 row%0d maskSel", i), 32'(capMask), 32'(v.eMask));
      chk($sformatf("R4 row%0d segSel", i), 32'(capSeg), 32'(v.eSeg));
      chk($sformatf("R4 row%0d regIdx", i), 32'(capIdx), 32'(v.eIdx));
      chk($sformatf("R10 row%0d wrData", i), capWr, v.d);
      chk($sformatf("R5 row%0d rdData", i), capRd, v.eRd);
      chk($sformatf("R1 row%0d strobe drops", i), 32'(afterStb), 32'h0);
    end

    // R1: enable held low yields one strobe only
    @(negedge clk);
    csAN = 1'b0; avN = 1'b1; ac = 10'h003; dq = 32'h1; enN = 1'b0;
    @(negedge clk);
    chk("R1 held low first clock", 32'(stbNow()), 32'(S_CMP));
    @(negedge clk);
    chk("R1 held low second clock", 32'(stbNow()), 32'h0);
    @(negedge clk);
    chk("R1 held low third clock", 32'(stbNow()), 32'h0);
    enN = 1'b1;
    @(negedge clk);

    // R2: deselected write is ignored
    doCyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h081, 32'h0);
    chk("R2 deselected no strobe", 32'(capStb), 32'h0);
    doCyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'h081, 32'h0);
    chk("R2 cfg unchanged via csBN", capRd, 32'h34);
    // device select: page 3, enable bit 0
    doCyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0B1, 32'h03);
    doCyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0B1, 32'h0);
    chk("R2 devsel match strobe", 32'(capStb), 32'(S_RRD));
    chk("R2 devsel match read", capRd, 32'h03);
    doCyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0B1, 32'h05);
    doCyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0B1, 32'h0);
    chk("R2 devsel page mismatch", 32'(capStb), 32'h0);
    chk("R2 outputs held", capRd, 32'h03);
    doCyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0B1, 32'h13);
    doCyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0B1, 32'h0);
    chk("R2 devsel enable bit set", 32'(capStb), 32'h0);

    // R8: software mode (pointer is 0)
    doCyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h081, 32'h35);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 32'h103);
    chk("R8 instruction load no strobe", 32'(capStb), 32'h0);
    doCyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h155, 32'h77);
    chk("R8 executes held compare", 32'(capStb), 32'(S_CMP));
    chk("R8 segment from instruction", 32'(capSeg), 32'h1);
    chk("R8 address from pointer", 32'(capAddr), 32'h0);
    chk("R8 data on wrData", capWr, 32'h77);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 32'h002);
    doCyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'h2AA, 32'h88);
    chk("R8 indirect write strobe", 32'(capStb), 32'(S_MWR));
    chk("R8 indirect write ignores ac", 32'(capAddr), 32'h0);
    chk("R8 indirect write no mask", 32'(capMask), 32'h0);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 32'h081);
    doCyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 32'h34);
    chk("R8 register write back to hardware", 32'(capStb), 32'(S_RWR));
    doCyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h2AA, 32'h99);
    chk("R3 direct write after return", 32'(capAddr), 32'h2AA);
    chk("R6 mask field applied", 32'(capMask), 32'h2);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0A1, 32'h0);
    chk("R7 pointer after software write", capRd, 32'h1);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0C1, 32'h0);
    chk("R5 instruction register read", capRd, 32'h081);

    // R11: reset in mid run
    resetDut();
    chk("R11 strobes after second reset", 32'(stbNow()), 32'h0);
    chk("R11 rdData after second reset", rdData, 32'h0);
    doCyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h0B1, 32'h0);
    chk("R11 devsel enable bit at reset", capRd, 32'h10);
    doCyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h011, 32'h5);
    chk("R11 hardware mode direct write", 32'(capStb), 32'(S_MWR));
    chk("R11 mask field cleared", 32'(capMask), 32'h0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule